// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

This peripheral holds two 16-bit down-counters, called timer A and timer B. Each one advances on a periodic tick enable supplied by the surrounding system. A counter loaded with N underflows after N+1 enabled periods, so software writes the wanted interval minus one. Each timer runs in one of two modes. In free-running mode it reloads from its latch at every underflow. In single-shot mode it starts when the upper latch byte is written and stops by itself at its first underflow. Timer B can be switched to count timer A underflows instead of ticks, which chains the two into a single long interval.

A byte-wide register bus gives access to both reload latches, both control registers and a shared interrupt register. Software writes the latch low byte first and the high byte second, because the high-byte write is the one that commits a new value. Writes to the interrupt register set or clear mask bits, depending on bit 7 of the written byte. Reads of the interrupt register return the pending underflow flags and clear them. The interrupt output stays high while any pending flag is also enabled in the mask.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, every readable register (offsets 0 to 6) reads 0x00 and `irqOut` is low.
- R2: A timer whose counter holds N, with its run bit (control bit 0) set, underflows on the (N+1)th cycle of its count enable. The counter does not change on cycles where the enable is low.
- R3: Latch bytes sit at offset 0 (A low), 1 (A high), 2 (B low) and 3 (B high). Writing a low byte alone leaves the counter unchanged. Writing a high byte while the timer is stopped copies {high, latched low} into the counter. Writing a high byte while the timer runs in free-running mode changes only the latch.
- R4: With control bit 3 clear, a timer reloads its latch value at every underflow and keeps running.
- R5: With control bit 3 set, writing the high latch byte loads the counter and sets the run bit. At the next underflow the run bit clears by itself and the counter holds the latch value.
- R6: Writing a control register (offset 4 for A, 5 for B) with bit 0 clear stops the timer, and its count then holds under further ticks.
- R7: When timer B control bit 6 is set (control value 0x48 means single-shot with cascade), timer B decrements once per timer A underflow and ignores ticks. Control registers read back bits 0, 3 and 6 (bit 6 only for B), with all other bits 0.
- R8: A write to offset 6 with bit 7 set enables every mask bit that is 1 in bits 1:0. With bit 7 clear, it disables them. Bit 0 belongs to timer A and bit 1 to timer B.
- R9: Every underflow sets its pending flag, whatever the mask says. A read of offset 6 returns the flags in bits 1:0 and clears them.
- R10: Bit 7 of an offset 6 read, and `irqOut`, are 1 exactly when some pending flag is also enabled.
- R11: Reads of offsets 0 to 3 return the live counter bytes, not the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Periodic count enable |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (status read clears flags) |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| irqOut | output | 1 | Interrupt request |

## Verification
A wrong count or reload value shows up in the live count bytes on the next read. An off-by-one in underflow detection moves the cycle in which the single-shot run bit drops, and a sweep over small load values, polling after every single tick, catches that shift exactly. A wrong cascade source makes timer B move on plain ticks, which is visible as soon as ticks arrive while timer A is stopped. Mask or flag errors appear on `irqOut` and in the status byte in the same cycle as the underflow or the register write that causes them.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W = 2 * DATA_W;
  localparam int ADDR_W = 3;
  localparam int NUM_TMR = 2;

  localparam logic [ADDR_W-1:0] OFS_A_LO = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_A_HI = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_B_LO = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_B_HI = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CTL_A = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CTL_B = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_IRQ = 3'd6;

  localparam int BIT_RUN = 0;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_CASCADE = 6;
  localparam int BIT_SETCLR = 7;

  typedef struct packed {
    logic [NUM_TMR-1:0] wrLo;
    logic [NUM_TMR-1:0] wrHi;
    logic [NUM_TMR-1:0] wrCtl;
    logic [DATA_W-1:0]  wrData;
  } tmr_strobe_t;
endpackage

// File: rtl/timer_channel.sv
module timer_channel
  import cascade_timer_pkg::*;
#(
  parameter bit HAS_CASCADE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cascadeIn,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic              wrCtl,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] ctlRead,
  output logic              underflow
);
  logic [CNT_W-1:0] latchVal;
  logic             runBit;
  logic             oneShot;
  logic             cascadeSel;
  logic             countEn;
  logic             hiLoads;

  generate
    if (HAS_CASCADE) begin : g_casc
      always_ff @(posedge clk) begin
        if (!rstN) cascadeSel <= 1'b0;
        else if (wrCtl) cascadeSel <= wrData[BIT_CASCADE];
      end
      assign countEn = cascadeSel ? cascadeIn : tickEn;
    end else begin : g_plain
      assign cascadeSel = 1'b0;
      assign countEn = tickEn;
    end
  endgenerate

  assign underflow = runBit && countEn && (count == '0);
  assign hiLoads = wrHi && (!runBit || oneShot);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchVal <= '0;
    end else begin
      if (wrLo) latchVal[DATA_W-1:0] <= wrData;
      if (wrHi) latchVal[CNT_W-1:DATA_W] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (hiLoads) begin
      count <= {wrData, latchVal[DATA_W-1:0]};
    end else if (runBit && countEn) begin
      count <= (count == '0) ? latchVal : count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      oneShot <= 1'b0;
    end else if (wrCtl) begin
      runBit  <= wrData[BIT_RUN];
      oneShot <= wrData[BIT_ONESHOT];
    end else if (wrHi && oneShot) begin
      runBit <= 1'b1;
    end else if (underflow && oneShot) begin
      runBit <= 1'b0;
    end
  end

  always_comb begin
    ctlRead = '0;
    ctlRead[BIT_RUN] = runBit;
    ctlRead[BIT_ONESHOT] = oneShot;
    ctlRead[BIT_CASCADE] = cascadeSel;
  end

  // R2: a running, enabled, nonzero counter steps down by one
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && countEn && count != '0 && !wrHi) |=> count == $past(count) - 1'b1);
  // R2: no enable, no write, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !wrHi) |=> $stable(count));
  // R4: underflow reloads from the latch
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !wrHi && !wrLo) |=> count == $past(latchVal));
  // R5: single-shot stops at underflow
  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && oneShot && !wrCtl && !wrHi) |=> !runBit);
  // R5: high-byte write starts a single-shot timer
  a_r5_hi_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && oneShot && !wrCtl) |=> runBit);
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import cascade_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  tmr_strobe_t       strobes,
  output logic [CNT_W-1:0]  countA,
  output logic [CNT_W-1:0]  countB,
  output logic [DATA_W-1:0] ctlA,
  output logic [DATA_W-1:0] ctlB,
  output logic              uflA,
  output logic              uflB
);
  timer_channel #(.HAS_CASCADE(1'b0)) chanA_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cascadeIn(1'b0),
    .wrLo(strobes.wrLo[0]), .wrHi(strobes.wrHi[0]), .wrCtl(strobes.wrCtl[0]),
    .wrData(strobes.wrData), .count(countA), .ctlRead(ctlA), .underflow(uflA)
  );

  timer_channel #(.HAS_CASCADE(1'b1)) chanB_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cascadeIn(uflA),
    .wrLo(strobes.wrLo[1]), .wrHi(strobes.wrHi[1]), .wrCtl(strobes.wrCtl[1]),
    .wrData(strobes.wrData), .count(countB), .ctlRead(ctlB), .underflow(uflB)
  );

  // R7: in cascade mode, timer B holds whenever timer A does not underflow
  a_r7_cascade_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctlB[BIT_CASCADE] && !uflA && !strobes.wrHi[1] && !strobes.wrCtl[1]) |=> $stable(countB));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import cascade_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  countA,
  input  logic [CNT_W-1:0]  countB,
  input  logic [DATA_W-1:0] ctlA,
  input  logic [DATA_W-1:0] ctlB,
  input  logic              uflA,
  input  logic              uflB,
  output tmr_strobe_t       strobes,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  logic [NUM_TMR-1:0] pendFlags;
  logic [NUM_TMR-1:0] irqMask;
  logic [NUM_TMR-1:0] uflVec;
  logic               wrEn;
  logic               wrIrq;
  logic               rdStatus;
  logic               anyActive;

  assign wrEn = busSel && busWr;
  assign wrIrq = wrEn && (busAddr == OFS_IRQ);
  assign rdStatus = busSel && busRd && (busAddr == OFS_IRQ);
  assign uflVec = {uflB, uflA};

  always_comb begin
    strobes = '0;
    strobes.wrData = busWdata;
    strobes.wrLo[0] = wrEn && (busAddr == OFS_A_LO);
    strobes.wrHi[0] = wrEn && (busAddr == OFS_A_HI);
    strobes.wrLo[1] = wrEn && (busAddr == OFS_B_LO);
    strobes.wrHi[1] = wrEn && (busAddr == OFS_B_HI);
    strobes.wrCtl[0] = wrEn && (busAddr == OFS_CTL_A);
    strobes.wrCtl[1] = wrEn && (busAddr == OFS_CTL_B);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendFlags <= '0;
    end else begin
      pendFlags <= (rdStatus ? '0 : pendFlags) | uflVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqMask <= '0;
    end else if (wrIrq) begin
      if (busWdata[BIT_SETCLR]) irqMask <= irqMask | busWdata[NUM_TMR-1:0];
      else irqMask <= irqMask & ~busWdata[NUM_TMR-1:0];
    end
  end

  assign anyActive = |(pendFlags & irqMask);
  assign irqOut = anyActive;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_A_LO:  busRdata = countA[DATA_W-1:0];
      OFS_A_HI:  busRdata = countA[CNT_W-1:DATA_W];
      OFS_B_LO:  busRdata = countB[DATA_W-1:0];
      OFS_B_HI:  busRdata = countB[CNT_W-1:DATA_W];
      OFS_CTL_A: busRdata = ctlA;
      OFS_CTL_B: busRdata = ctlB;
      OFS_IRQ: begin
        busRdata[NUM_TMR-1:0] = pendFlags;
        busRdata[BIT_SETCLR] = anyActive;
      end
      default:   busRdata = '0;
    endcase
  end

  // R9: a status read leaves only flags raised in that same cycle
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus |=> pendFlags == $past(uflVec));
  // R9: an underflow always raises its flag
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    uflA |=> pendFlags[0]);
  // R8: set-type write enables the given bits
  a_r8_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrIrq && busWdata[BIT_SETCLR]) |=> (irqMask & $past(busWdata[NUM_TMR-1:0])) == $past(busWdata[NUM_TMR-1:0]));
  // R8: clear-type write disables the given bits
  a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrIrq && !busWdata[BIT_SETCLR]) |=> (irqMask & $past(busWdata[NUM_TMR-1:0])) == '0);
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import cascade_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  tmr_strobe_t       strobes;
  logic [CNT_W-1:0]  countA;
  logic [CNT_W-1:0]  countB;
  logic [DATA_W-1:0] ctlA;
  logic [DATA_W-1:0] ctlB;
  logic              uflA;
  logic              uflB;

  timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .countA(countA), .countB(countB),
    .ctlA(ctlA), .ctlB(ctlB), .uflA(uflA), .uflB(uflB), .strobes(strobes),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  timer_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobes(strobes),
    .countA(countA), .countB(countB), .ctlA(ctlA), .ctlB(ctlB),
    .uflA(uflA), .uflB(uflB)
  );
endmodule

// File: tb/cascade_timer_pair_tb_top.sv
module cascade_timer_pair_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqOut;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cascade_timer_pair dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0; busRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic rdCount(input logic [2:0] loAddr, output int v);
    logic [7:0] lo, hi;
    rd(loAddr, lo);
    rd(loAddr + 3'd1, hi);
    v = {hi, lo};
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 0);
    end
    chk("R1 irqOut", irqOut, 0);

    // R3 / R11: low write alone does nothing, high write while stopped loads
    wr(3'd0, 8'h34);
    rdCount(3'd0, v);
    chk("R3 low write leaves counter", v, 0);
    wr(3'd1, 8'h12);
    rdCount(3'd0, v);
    chk("R11 live count after stopped load", v, 16'h1234);

    // R2 / R6: run, count, stop
    wr(3'd4, 8'h01);
    ticks(3);
    rdCount(3'd0, v);
    chk("R2 three ticks", v, 16'h1231);
    repeat (4) @(negedge clk);
    rdCount(3'd0, v);
    chk("R2 no change without ticks", v, 16'h1231);
    wr(3'd1, 8'h55);
    rdCount(3'd0, v);
    chk("R3 running high write keeps count", v, 16'h1231);
    wr(3'd4, 8'h00);
    ticks(5);
    rdCount(3'd0, v);
    chk("R6 stopped count holds", v, 16'h1231);

    // R2 / R5 sweep: single-shot underflow after N+1 ticks
    rd(3'd6, d);
    for (int n = 0; n < 8; n++) begin
      int k;
      wr(3'd4, 8'h08);
      wr(3'd0, 8'(n));
      wr(3'd1, 8'h00);
      rd(3'd4, d);
      chk("R5 high write starts", d, 8'h09);
      k = 0;
      while (k < 20) begin
        ticks(1);
        k++;
        rd(3'd4, d);
        if (d[0] == 1'b0) break;
      end
      chk("R2 underflow tick count", k, n + 1);
      chk("R5 run bit cleared", d, 8'h08);
      rdCount(3'd0, v);
      chk("R5 count reloaded", v, n);
      rd(3'd6, d);
      chk("R9 flag A pending", d, 8'h01);
      rd(3'd6, d);
      chk("R9 flag cleared by read", d, 8'h00);
    end

    // R7 cascade
    wr(3'd5, 8'h48);
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h00);
    rd(3'd5, d);
    chk("R7 control B readback", d, 8'h49);
    ticks(3);
    rdCount(3'd2, v);
    chk("R7 B ignores ticks", v, 2);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    ticks(5);
    rd(3'd5, d);
    chk("R7 B still running", d, 8'h49);
    rdCount(3'd2, v);
    chk("R7 B after two A underflows", v, 0);
    ticks(1);
    rd(3'd5, d);
    chk("R7 B stopped on third A underflow", d, 8'h48);
    rdCount(3'd0, v);
    chk("R4 A reloaded", v, 1);
    rd(3'd6, d);
    chk("R9 both flags", d, 8'h03);

    // R4 free-running period
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    ticks(4);
    rd(3'd6, d);
    chk("R4 first underflow", d, 8'h01);
    rdCount(3'd0, v);
    chk("R4 reload value", v, 3);
    ticks(2);
    rdCount(3'd0, v);
    chk("R4 mid period", v, 1);
    ticks(2);
    rd(3'd6, d);
    chk("R4 second underflow", d, 8'h01);
    rd(3'd4, d);
    chk("R4 still running", d, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd6, d);

    // R8 / R10 interrupts
    wr(3'd6, 8'h81);
    wr(3'd4, 8'h08);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    chk("R10 irq low before underflow", irqOut, 0);
    ticks(1);
    chk("R10 irq high on enabled flag", irqOut, 1);
    rd(3'd6, d);
    chk("R10 status with bit7", d, 8'h81);
    chk("R10 irq drops after read", irqOut, 0);
    wr(3'd5, 8'h08);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    ticks(1);
    chk("R10 masked flag no irq", irqOut, 0);
    wr(3'd6, 8'h82);
    chk("R8 set B mask", irqOut, 1);
    wr(3'd6, 8'h02);
    chk("R8 clear B mask", irqOut, 0);
    rd(3'd6, d);
    chk("R9 masked flag still pending", d, 8'h02);
    wr(3'd6, 8'h01);
    wr(3'd4, 8'h08);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    ticks(1);
    chk("R8 cleared A mask", irqOut, 0);
    rd(3'd6, d);
    chk("R9 flag A raised while masked", d, 8'h01);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule